// File: doc/BRIEF.md
# Channel access transmit controller

This block runs one transmit burst on a shared reverse control channel. A host feeds message words in one bit at a time through a serial load port and marks the final word of the message with an end flag. It also drives three control inputs: a transmit reset pulse, an abort-enable level and a hold level. The block sends the message most significant bit first, one bit for each bit strobe. It reports its progress through in-progress, abort, underrun and buffer-empty flags.

The transmitter enable line is an open-drain wire shared with the host. The block can only pull it low, through `en_pull_oe`, and it reads the wired level back on `en_sense`. While abort is enabled, the block watches the busy/idle input. It gives up the burst in either of two cases: the channel turns busy before 56 bits have gone out, or the channel still reads idle once 104 bits have gone out. In both cases it pulls the enable line low in that same cycle.

A control FSM holds the burst. In `ST_IDLE` the block waits for the first word. A completed first word moves it to `ST_SEND`, or to `ST_HELD` if hold is high on the final load strobe. `ST_HELD` moves to `ST_SEND` once hold is low. From `ST_SEND` there are four outcomes:
- an abort condition moves it to `ST_ABORT`;
- the end of a word with another word buffered keeps it in `ST_SEND`;
- the end of the end-flagged word moves it to `ST_DONE`;
- the end of any other word with nothing buffered moves it to `ST_UNDER`.

`ST_DONE`, `ST_ABORT` and `ST_UNDER` are held. A transmit reset returns every state to `ST_IDLE`.

Top module: `chan_tx_ctrl`

## Requirements
- R1: After `rst_n` is released, `in_prog`, `aborted`, `underrun` and `en_pull_oe` are 0 and `buf_empty` is 1.
- R2: A word is WORD_W load strobes of `ld_bit`, first bit = word MSB. When the first word completes with `hold` low, `in_prog` is 1 after that edge. `tx_data` then shows the word MSB first, and each accepted `bit_stb` moves to the next bit.
- R3: If `hold` is 1 on the final load strobe of the first word, `in_prog` stays 0 and bit strobes send nothing until `hold` is 0. The first clock edge with `hold` low sets `in_prog`, and the first bit out is the word's MSB.
- R4: While a word is sending, a later completed word is buffered and `buf_empty` is 0. On the strobe that sends the last bit of the current word, the buffered word takes over and `buf_empty` returns to 1. Bits continue without a gap.
- R5: With `abort_en`=1 and `busy`=1 (1 = busy) while fewer than 56 bits have been sent, the block aborts.
- R6: With `abort_en`=1 and `busy`=0 once 104 or more bits have been sent, the block aborts.
- R7: On abort, `en_pull_oe` is 1 in the same cycle that the condition is present. `aborted` is 1 from the next edge and stays 1 until a transmit reset. `en_pull_oe` stays 1 while `aborted` and `abort_en` are both 1.
- R8: With `abort_en`=0, `en_pull_oe` is never 1 and no abort takes place, whatever `busy` does.
- R9: After the last bit of the word loaded with `ld_end`=1 is strobed, `in_prog` falls to 0, with no abort and no underrun.
- R10: If a word without the end flag finishes and no word is buffered, `underrun` becomes 1 and `in_prog` stays 1.
- R11: A `txrst` pulse clears `aborted`, `underrun`, `in_prog`, the bit count and the buffer (`buf_empty`=1), and releases `en_pull_oe`.
- R12: A `bit_stb` while `en_sense` is 0 is ignored: `tx_data` keeps its bit and the bit count does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txrst | input | 1 | Transmit reset command pulse |
| abort_en | input | 1 | Lets the block pull the enable line and abort |
| hold | input | 1 | Keeps the preloaded first word from starting |
| ld_valid | input | 1 | Serial load strobe |
| ld_bit | input | 1 | Serial load data, MSB of each word first |
| ld_end | input | 1 | End-of-message flag, sampled on a word's final load strobe |
| bit_stb | input | 1 | Send-one-bit strobe |
| busy | input | 1 | Channel status, 1 = busy, 0 = idle |
| en_sense | input | 1 | Sensed level of the open-drain enable line |
| tx_data | output | 1 | Bit currently presented for transmission |
| en_pull_oe | output | 1 | Pulls the enable line low when 1 |
| in_prog | output | 1 | Transmission in progress |
| aborted | output | 1 | Sticky abort flag |
| underrun | output | 1 | Sticky underrun flag |
| buf_empty | output | 1 | Word buffer can take the next word |

## Verification
A table of busy-onset points probes both abort windows on either side of their edges: busy at bit 0 and at bit 55 must abort, busy at bit 56, 103 or 104 must not, and a channel that never turns busy must abort at bit 104. A design with an off-by-one window would abort a burst that should finish, or finish one that should stop. The bench samples `en_pull_oe` in the same cycle that busy appears, so a registered pull-down that arrives one cycle late is caught. Directed cases cover the rest:
- hold released late, where a design that ignored hold would start sending early;
- an underrun with the buffer empty mid-message;
- bit strobes while the sensed line is low, where a design that ignored the line would skip bits;
- a transmit reset after an abort, where stale flags would remain.

// File: rtl/chan_tx_pkg.sv
package chan_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HELD,
        ST_SEND,
        ST_DONE,
        ST_ABORT,
        ST_UNDER
    } ctl_state_t;
endpackage

// File: rtl/tx_loader.sv
module tx_loader #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_valid,
    input  logic              ld_bit,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int CW = $clog2(WORD_W + 1);

    logic [WORD_W-2:0] part_q;
    logic [CW-1:0]     cnt_q;

    assign word      = {part_q, ld_bit};
    assign word_done = ld_valid && (cnt_q == CW'(WORD_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (ld_valid) begin
            part_q <= word[WORD_W-2:0];
            cnt_q  <= word_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_bitcnt.sv
module tx_bitcnt #(
    parameter int EARLY_BITS = 56,
    parameter int LATE_BITS  = 104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic in_early,
    output logic past_late
);
    localparam int CNT_MAX = LATE_BITS + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv && cnt_q != CW'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign in_early  = cnt_q < CW'(EARLY_BITS);
    assign past_late = cnt_q >= CW'(LATE_BITS);
endmodule

// File: rtl/chan_tx_ctrl.sv
module chan_tx_ctrl
    import chan_tx_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int EARLY_BITS = 56,
    parameter int LATE_BITS  = 104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txrst,
    input  logic abort_en,
    input  logic hold,
    input  logic ld_valid,
    input  logic ld_bit,
    input  logic ld_end,
    input  logic bit_stb,
    input  logic busy,
    input  logic en_sense,
    output logic tx_data,
    output logic en_pull_oe,
    output logic in_prog,
    output logic aborted,
    output logic underrun,
    output logic buf_empty
);
    localparam int IW = $clog2(WORD_W + 1);

    ctl_state_t state_q, state_d;

    logic [WORD_W-1:0] sh_q, buf_q, word;
    logic [IW-1:0]     bidx_q;
    logic              cur_end_q, buf_end_q, buf_full_q;
    logic              word_done, in_early, past_late;
    logic              abort_now, step, word_last;

    tx_loader #(.WORD_W(WORD_W)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (txrst),
        .ld_valid  (ld_valid),
        .ld_bit    (ld_bit),
        .word_done (word_done),
        .word      (word)
    );

    tx_bitcnt #(.EARLY_BITS(EARLY_BITS), .LATE_BITS(LATE_BITS)) u_bitcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (txrst),
        .adv       (step),
        .in_early  (in_early),
        .past_late (past_late)
    );

    // Abort windows: busy too early, or idle persisting too long.
    assign abort_now = abort_en && (state_q == ST_SEND) &&
                       ((busy && in_early) || (!busy && past_late));
    assign step      = bit_stb && en_sense && (state_q == ST_SEND) && !abort_now;
    assign word_last = step && (bidx_q == IW'(WORD_W - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (word_done) state_d = hold ? ST_HELD : ST_SEND;
            ST_HELD:  if (!hold) state_d = ST_SEND;
            ST_SEND: begin
                if (abort_now)                    state_d = ST_ABORT;
                else if (word_last && !buf_full_q) state_d = cur_end_q ? ST_DONE : ST_UNDER;
            end
            ST_DONE, ST_ABORT, ST_UNDER: state_d = state_q;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= ST_IDLE;
        else if (txrst) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // Shifter and word buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            bidx_q     <= '0;
            cur_end_q  <= 1'b0;
            buf_q      <= '0;
            buf_end_q  <= 1'b0;
            buf_full_q <= 1'b0;
        end else if (txrst) begin
            bidx_q     <= '0;
            cur_end_q  <= 1'b0;
            buf_full_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && word_done) begin
                sh_q      <= word;
                cur_end_q <= ld_end;
                bidx_q    <= '0;
            end else if (word_last && buf_full_q) begin
                sh_q      <= buf_q;
                cur_end_q <= buf_end_q;
                bidx_q    <= '0;
            end else if (step) begin
                sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                bidx_q <= bidx_q + 1'b1;
            end

            if (word_done && !buf_full_q &&
                (state_q == ST_SEND || state_q == ST_HELD)) begin
                buf_q      <= word;
                buf_end_q  <= ld_end;
                buf_full_q <= 1'b1;
            end else if (word_last && buf_full_q) begin
                buf_full_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        tx_data    = (state_q == ST_SEND) && sh_q[WORD_W-1];
        en_pull_oe = abort_en && (abort_now || state_q == ST_ABORT);
        in_prog    = (state_q == ST_SEND) || (state_q == ST_UNDER);
        aborted    = (state_q == ST_ABORT);
        underrun   = (state_q == ST_UNDER);
        buf_empty  = !buf_full_q;
    end
endmodule

module chan_tx_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic txrst,
    input logic abort_en,
    input logic en_pull_oe,
    input logic in_prog,
    input logic aborted,
    input logic underrun,
    input logic buf_empty
);
    assert_no_pull_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_en |-> !en_pull_oe);

    assert_abort_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aborted && !txrst) |=> aborted);

    assert_abort_pulls_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aborted && abort_en) |-> en_pull_oe);

    assert_txrst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txrst |=> (!aborted && !in_prog && !underrun && buf_empty));

    assert_underrun_keeps_prog_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> in_prog);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(aborted && underrun));
endmodule

bind chan_tx_ctrl chan_tx_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txrst      (txrst),
    .abort_en   (abort_en),
    .en_pull_oe (en_pull_oe),
    .in_prog    (in_prog),
    .aborted    (aborted),
    .underrun   (underrun),
    .buf_empty  (buf_empty)
);

// File: tb/chan_tx_ctrl_test.sv
module chan_tx_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int NW = 14;
    // abort_en, busy onset bit, expect abort, expected bit count at abort
    localparam int VEC [8][4] = '{
        '{1,   0, 1,   0},
        '{1,  55, 1,  55},
        '{1,  56, 0,   0},
        '{1, 103, 0,   0},
        '{1, 104, 0,   0},
        '{1, 999, 1, 104},
        '{0,   0, 0,   0},
        '{0, 999, 0,   0}
    };

    logic clk = 0, rst_n = 0;
    logic txrst = 0, abort_en = 0, hold = 0;
    logic ld_valid = 0, ld_bit = 0, ld_end = 0, bit_stb = 0, busy = 0, ext_low = 0;
    logic en_sense, tx_data, en_pull_oe, in_prog, aborted, underrun, buf_empty;

    int checks = 0, errors = 0;
    logic [2*W-1:0] got;

    assign en_sense = !en_pull_oe && !ext_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_tx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .txrst(txrst), .abort_en(abort_en), .hold(hold),
        .ld_valid(ld_valid), .ld_bit(ld_bit), .ld_end(ld_end), .bit_stb(bit_stb),
        .busy(busy), .en_sense(en_sense), .tx_data(tx_data), .en_pull_oe(en_pull_oe),
        .in_prog(in_prog), .aborted(aborted), .underrun(underrun), .buf_empty(buf_empty)
    );

    function automatic logic [W-1:0] msg(int i);
        return W'(8'h3C + i * 8'h29);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_txrst();
        txrst = 1; tick(); txrst = 0;
    endtask

    task automatic load_word(logic [W-1:0] w, logic e);
        for (int i = 0; i < W; i++) begin
            ld_valid = 1; ld_bit = w[W-1-i]; ld_end = e;
            tick();
        end
        ld_valid = 0; ld_end = 0;
    endtask

    task automatic strobe_bits(int n);
        for (int i = 0; i < n; i++) begin
            got = {got[2*W-2:0], tx_data};
            bit_stb = 1; tick(); bit_stb = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 in_prog", in_prog, 0);
        check("R1 aborted", aborted, 0);
        check("R1 underrun", underrun, 0);
        check("R1 en_pull_oe", en_pull_oe, 0);
        check("R1 buf_empty", buf_empty, 1);

        // Table: abort windows R5 R6 R8, completion R9, data R2
        for (int v = 0; v < 8; v++) begin
            int cnt, oe_cnt, mism, ldw, ldb, cyc;
            bit loading, seen, fin;
            string tag;
            pulse_txrst();
            abort_en = VEC[v][0][0];
            cnt = 0; oe_cnt = -1; mism = 0; ldw = 0; ldb = 0; cyc = 0;
            loading = 0; seen = 0; fin = 0;
            while (!fin && cyc < 4000) begin
                busy = (cnt >= VEC[v][1]);
                #1;
                if (en_pull_oe && oe_cnt < 0) oe_cnt = cnt;
                if (!loading && ldw < NW && buf_empty && !aborted) begin
                    loading = 1; ldb = 0;
                end
                if (loading) begin
                    ld_valid = 1; ld_bit = msg(ldw)[W-1-ldb]; ld_end = (ldw == NW-1);
                end
                if (cyc % 16 == 15 && in_prog && !aborted && !en_pull_oe) begin
                    bit_stb = 1;
                    if (tx_data != msg(cnt / W)[W-1-(cnt % W)]) mism++;
                    cnt++;
                end
                @(posedge clk);
                if (loading) begin
                    ldb++;
                    if (ldb == W) begin loading = 0; ldw++; end
                end
                @(negedge clk);
                ld_valid = 0; ld_end = 0; bit_stb = 0;
                if (in_prog) seen = 1;
                if (seen && !in_prog) fin = 1;
                cyc++;
            end
            if (VEC[v][0] == 0)            tag = "R8";
            else if (VEC[v][1] < 56)       tag = "R5";
            else if (VEC[v][2] == 1)       tag = "R6";
            else                           tag = "R9";
            check(tag, aborted, VEC[v][2]);
            if (VEC[v][2] == 1) begin
                check(tag, oe_cnt, VEC[v][3]);
                check("R7 line held low", en_pull_oe, 1);
            end else begin
                check(tag, oe_cnt, -1);
                check("R9 bits sent", cnt, NW * W);
                check("R9 in_prog clear", in_prog, 0);
            end
            check("R2 bit order", mism, 0);
            busy = 0;
        end

        // R7 same-cycle pull and sticky flag, then R11 reset command
        pulse_txrst();
        abort_en = 1;
        load_word(8'hC3, 1);
        busy = 1; #1;
        check("R7 same cycle", en_pull_oe, 1);
        check("R7 not yet flagged", aborted, 0);
        tick();
        check("R7 aborted", aborted, 1);
        busy = 0; tick();
        check("R7 sticky", aborted, 1);
        pulse_txrst();
        check("R11 aborted", aborted, 0);
        check("R11 en_pull_oe", en_pull_oe, 0);
        check("R11 in_prog", in_prog, 0);
        check("R11 buf_empty", buf_empty, 1);
        abort_en = 0;

        // R3 hold before start
        pulse_txrst();
        hold = 1;
        load_word(8'hB6, 1);
        check("R3 held no prog", in_prog, 0);
        strobe_bits(3);
        check("R3 strobes ignored", in_prog, 0);
        hold = 0; tick();
        check("R3 released", in_prog, 1);
        check("R3 first bit MSB", tx_data, 1);
        got = '0;
        strobe_bits(W);
        check("R2 word out", int'(got[W-1:0]), 8'hB6);
        check("R9 done", in_prog, 0);

        // R4 buffering
        pulse_txrst();
        load_word(8'h71, 0);
        load_word(8'hE8, 1);
        check("R4 buffer full", buf_empty, 0);
        got = '0;
        strobe_bits(W - 1);
        check("R4 still full", buf_empty, 0);
        strobe_bits(1);
        check("R4 emptied", buf_empty, 1);
        strobe_bits(W);
        check("R4 seamless", int'(got), 16'h71E8);
        check("R4 finished", in_prog, 0);

        // R10 underrun
        pulse_txrst();
        load_word(8'h0F, 0);
        strobe_bits(W);
        check("R10 underrun", underrun, 1);
        check("R10 in_prog kept", in_prog, 1);
        check("R10 no abort", aborted, 0);

        // R12 strobes ignored while line sensed low
        pulse_txrst();
        load_word(8'h5A, 1);
        ext_low = 1;
        got = '0;
        strobe_bits(3);
        check("R12 bit held", tx_data, 0);
        check("R12 still sending", in_prog, 1);
        ext_low = 0;
        got = '0;
        strobe_bits(W);
        check("R12 word intact", int'(got[W-1:0]), 8'h5A);
        check("R12 done", in_prog, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule